// File: doc/BRIEF.md
# One-Bit Dynamic Memory Device Interface with Output Control

This block is a clock-synchronous model of the device side of a one-bit-wide dynamic memory. It has a small storage array. The row and column halves of the cell address share one address bus. The row half is captured when the row strobe falls. The column half is captured when the column strobe falls while the row strobe is low. All strobes are active low and are sampled on the rising clock edge, so a "fall" means a strobe was sampled high at one edge and low at the next.

Each column-strobe cycle is one of three kinds, chosen by the write-enable line:
- a read,
- an early write, where write-enable is already low when the column strobe falls,
- a late write, where write-enable falls after the column strobe.

The block also decides when the three-state data output drives and what value it carries. The three-state pin is modelled as a data bit (`q_dat`) plus an enable (`q_oe`). Access time is a fixed number of clocks.

The output enable follows the column strobe only. A driven output stays valid after the row strobe returns high, so it can be used for hidden refresh. A cycle that holds the row strobe low and leaves the column strobe high is a refresh. It has no data activity.

Top module: `dram1b_core`

## Requirements
- R1: After reset `q_oe` is 0. At any clock edge where `cas_n` is sampled high, `q_oe` becomes 0 and stays 0 while `cas_n` stays high.
- R2: In a read cycle, `cas_n` falls at edge k with `ras_n` low and `we_n` high. At edge k+ACC_DLY, `q_oe` becomes 1 and `q_dat` carries the stored bit of the addressed cell. Before that edge `q_oe` is 0.
- R3: Once driven, `q_oe` and `q_dat` hold until `cas_n` is sampled high. This holds even if `ras_n` returns high first.
- R4: In an early write, `we_n` is low at the edge where `cas_n` falls. `din` is written to the addressed cell at that edge, and `q_oe` stays 0 for the whole cycle.
- R5: In a late write, `we_n` falls while a read cycle is in progress with `ras_n` low. `din` is written at that edge. `q_oe` still rises at edge k+ACC_DLY, and `q_dat` carries the cell value from before the write.
- R6: The row is the value of `addr` at the edge where `ras_n` falls. The column is the value of `addr` at the edge where `cas_n` falls. The cell index is {row, column}, with the row in the upper bits.
- R7: While `ras_n` is low and `cas_n` stays high, `q_oe` stays 0 and no cell changes, whatever `we_n` and `din` do.
- R8: If `cas_n` returns high before edge k+ACC_DLY, `q_oe` never becomes 1 in that cycle.
- R9: Several column cycles within one low period of `ras_n` (page mode) each address the row captured at the row-strobe fall.
- R10: A `cas_n` fall while `ras_n` is high starts no cycle. No cell is written and `q_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| q_dat | output | 1 | Output data bit; 0 when not driven |
| q_oe | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The bench drives and samples one time unit after each rising edge, so every result can be pinned to the edge that produced it. Consider a column-strobe fall sampled at edge k:
- `q_oe` is checked to be 0 after edges k through k+ACC_DLY-1.
- `q_oe` and `q_dat` are checked after edge k+ACC_DLY.
- An early write takes effect at edge k. A late write takes effect at the edge that samples `we_n` low.
- Both kinds of write are confirmed later through a read of the same cell.

A column-strobe rise clears the output by the next edge, and the checks sample there. The sweep covers every cell of an 8x8 array using an arithmetic data pattern.

// File: rtl/dram1b_pkg.sv
package dram1b_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_READ,
    CYC_EWR,
    CYC_LWR
  } cyc_e;
endpackage

// File: rtl/dram1b_strobes.sv
module dram1b_strobes (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic ras_fall,
  output logic cas_fall,
  output logic we_fall
);
  logic ras_p, cas_p, we_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_p <= 1'b1;
      cas_p <= 1'b1;
      we_p  <= 1'b1;
    end else begin
      ras_p <= ras_n;
      cas_p <= cas_n;
      we_p  <= we_n;
    end
  end

  assign ras_fall = ras_p & ~ras_n;
  // column strobe only opens a cycle while the row strobe is low (R10)
  assign cas_fall = cas_p & ~cas_n & ~ras_n;
  assign we_fall  = we_p & ~we_n;
endmodule

// File: rtl/dram1b_addr_latch.sv
module dram1b_addr_latch #(
  parameter int ADDR_W = 4,
  localparam int IDX_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_fall,
  input  logic              cas_fall,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  cell_idx
);
  logic [ADDR_W-1:0] row_q, col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (ras_fall) row_q <= addr;
      if (cas_fall) col_q <= addr;
    end
  end

  // at the column-strobe edge the column comes straight from the bus
  assign cell_idx = cas_fall ? {row_q, addr} : {row_q, col_q};
endmodule

// File: rtl/dram1b_cell_array.sv
module dram1b_cell_array #(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_bit;
  end

  // read-first registered port, block-RAM style
  always_ff @(posedge clk) begin
    if (rd_en) rd_bit <= mem[rd_idx];
  end
endmodule

// File: rtl/dram1b_q_ctrl.sv
module dram1b_q_ctrl
  import dram1b_pkg::*;
#(
  parameter int ACC_DLY = 4,
  localparam int CNT_W = $clog2(ACC_DLY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cas_fall,
  input  logic we_fall,
  input  logic rd_bit,
  output logic wr_en,
  output logic q_oe,
  output logic q_dat
);
  cyc_e             cyc;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             late_wr;

  assign late_wr = (cyc == CYC_READ) & we_fall & ~ras_n & ~cas_n;
  assign wr_en   = (cas_fall & ~we_n) | late_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc   <= CYC_IDLE;
      armed <= 1'b0;
      cnt   <= '0;
      q_oe  <= 1'b0;
      q_dat <= 1'b0;
    end else if (cas_n) begin
      cyc   <= CYC_IDLE;
      armed <= 1'b0;
      cnt   <= '0;
      q_oe  <= 1'b0;
      q_dat <= 1'b0;
    end else if (cas_fall) begin
      armed <= we_n;
      cnt   <= CNT_W'(ACC_DLY - 1);
      cyc   <= we_n ? CYC_READ : CYC_EWR;
    end else begin
      if (armed) begin
        if (cnt == '0) begin
          q_oe  <= 1'b1;
          q_dat <= rd_bit;
          armed <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (late_wr) cyc <= CYC_LWR;
    end
  end

  AST_HIZ_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    q_oe |-> !$past(cas_n)); // R1
  AST_Q_HELD: assert property (@(posedge clk) disable iff (rst)
    (q_oe && $past(q_oe)) |-> $stable(q_dat)); // R3
  AST_EWR_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_EWR) |-> !q_oe); // R4
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && cas_n) |-> !wr_en); // R7
  AST_RISE_AFTER_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(q_oe) |-> !$past(cas_fall)); // R8
endmodule

// File: rtl/dram1b_core.sv
module dram1b_core #(
  parameter int ADDR_W  = 4,
  parameter int ACC_DLY = 4,
  localparam int IDX_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              q_dat,
  output logic              q_oe
);
  logic             ras_fall, cas_fall, we_fall;
  logic [IDX_W-1:0] cell_idx;
  logic             wr_en, rd_bit;

  dram1b_strobes u_strb (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ras_fall(ras_fall), .cas_fall(cas_fall), .we_fall(we_fall)
  );

  dram1b_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .ras_fall(ras_fall), .cas_fall(cas_fall),
    .addr(addr), .cell_idx(cell_idx)
  );

  dram1b_cell_array #(.IDX_W(IDX_W)) u_cells (
    .clk(clk), .wr_en(wr_en), .wr_idx(cell_idx), .wr_bit(din),
    .rd_en(cas_fall), .rd_idx(cell_idx), .rd_bit(rd_bit)
  );

  dram1b_q_ctrl #(.ACC_DLY(ACC_DLY)) u_qctl (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cas_fall(cas_fall), .we_fall(we_fall), .rd_bit(rd_bit),
    .wr_en(wr_en), .q_oe(q_oe), .q_dat(q_dat)
  );

  AST_NO_WRITE_RAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    ras_n |-> !wr_en); // R10
endmodule

// File: tb/dram1b_core_tb.sv
module dram1b_core_tb;
  localparam int AW  = 3;
  localparam int ACC = 3;
  localparam int N   = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic q_dat, q_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic model [N*N];

  always #2 clk = ~clk;

  dram1b_core #(.ADDR_W(AW), .ACC_DLY(ACC)) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .q_dat(q_dat), .q_oe(q_oe)
  );

  function automatic logic pat(input int idx);
    return logic'((((idx * 5) >> 2) ^ idx) & 1);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ras_open(input int row);
    addr = AW'(row); ras_n = 1'b0; tick();
  endtask

  task automatic ras_close();
    ras_n = 1'b1; tick();
  endtask

  // read cycle at column col of the open row; expects q_oe at edge k+ACC
  task automatic read_col(input int row, input int col, input string req);
    addr = AW'(col); we_n = 1'b1; cas_n = 1'b0; tick();
    for (int i = 0; i < ACC; i++) begin
      check({req, " R2 oe before delay"}, q_oe, 0);
      tick();
    end
    check({req, " R2 oe at delay"}, q_oe, 1);
    check({req, " R6 data"}, q_dat, model[row*N+col]);
    tick();
    check({req, " R3 held"}, q_dat, model[row*N+col]);
    cas_n = 1'b1; tick();
    check({req, " R1 cas high"}, q_oe, 0);
  endtask

  task automatic early_write(input int row, input int col, input logic d);
    addr = AW'(col); we_n = 1'b0; din = d; cas_n = 1'b0; tick();
    for (int i = 0; i <= ACC; i++) begin
      check("R4 early write no drive", q_oe, 0);
      tick();
    end
    cas_n = 1'b1; we_n = 1'b1; tick();
    model[row*N+col] = d;
  endtask

  task automatic late_write(input int row, input int col, input logic d);
    logic old;
    old = model[row*N+col];
    addr = AW'(col); we_n = 1'b1; cas_n = 1'b0; tick();
    we_n = 1'b0; din = d;
    check("R5 late write oe early", q_oe, 0);
    tick();
    for (int i = 1; i < ACC; i++) begin
      check("R5 late write oe early", q_oe, 0);
      tick();
    end
    check("R5 late write drives", q_oe, 1);
    check("R5 late write old data", q_dat, old);
    cas_n = 1'b1; we_n = 1'b1; tick();
    check("R1 after late write", q_oe, 0);
    model[row*N+col] = d;
  endtask

  initial begin
    repeat (3) tick();
    check("R1 reset oe", q_oe, 0);
    rst = 1'b0; tick();
    check("R1 idle oe", q_oe, 0);

    // early-write sweep, every row in page mode (R9)
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      for (int c = 0; c < N; c++) early_write(r, c, pat(r*N+c));
      ras_close();
    end
    // read sweep, page mode
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      for (int c = 0; c < N; c++) read_col(r, c, "R9 sweep");
      ras_close();
    end

    // late writes invert a diagonal, then read back
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      late_write(r, r, ~model[r*N+r]);
      ras_close();
    end
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      read_col(r, r, "R5 readback");
      ras_close();
    end

    // hidden refresh: RAS rises while output driven
    ras_open(5);
    addr = AW'(2); we_n = 1'b1; cas_n = 1'b0; tick();
    repeat (ACC) tick();
    check("R3 hidden driven", q_oe, 1);
    ras_n = 1'b1; tick(); tick();
    check("R3 oe after ras high", q_oe, 1);
    check("R3 data after ras high", q_dat, model[5*N+2]);
    cas_n = 1'b1; tick();
    check("R1 hidden end", q_oe, 0);

    // refresh-only cycle with activity on we_n/din/addr
    ras_open(3);
    for (int i = 0; i < 6; i++) begin
      we_n = logic'(i & 1); din = logic'((i >> 1) & 1); addr = AW'(i);
      tick();
      check("R7 refresh oe", q_oe, 0);
    end
    we_n = 1'b1; ras_close();
    ras_open(3);
    for (int c = 0; c < N; c++) read_col(3, c, "R7 cells unchanged");
    ras_close();

    // short CAS pulse shorter than access delay
    ras_open(6);
    addr = AW'(4); we_n = 1'b1; cas_n = 1'b0; tick();
    for (int i = 0; i < ACC - 1; i++) begin
      check("R8 short cas", q_oe, 0);
      tick();
    end
    cas_n = 1'b1;
    for (int i = 0; i < ACC + 2; i++) begin
      tick();
      check("R8 never drives", q_oe, 0);
    end
    ras_close();

    // CAS fall with RAS high: no cycle
    addr = AW'(1); we_n = 1'b0; din = ~model[2*N+1]; cas_n = 1'b0;
    for (int i = 0; i < ACC + 2; i++) begin
      tick();
      check("R10 ras high oe", q_oe, 0);
    end
    cas_n = 1'b1; we_n = 1'b1; tick();
    ras_open(2);
    read_col(2, 1, "R10 no write");
    ras_close();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule